// File: doc/BRIEF.md
# Activity-Triggered Memory Power Monitor

This block is a synchronous model of the automatic power gating found in asynchronous static memories. It registers the chip-select, write-strobe, address and data pins of the memory on every clock. Each sample is compared with the sample before it, and certain transitions count as wake events. A wake event raises a power-up flag and reloads a quiet-interval counter. When the counter runs out the flag drops, even if the memory is still selected. The memory's power therefore follows how often accesses happen, and not how long the select pulse lasts.

Whenever the sampled selects show the memory deselected, the block holds standby. It produces a level flag that shows the power state and a one-cycle pulse on each qualified wake event. A power controller or a power estimator in the surrounding chip uses these outputs. The block switches no supply and holds no memory array.

Top module: `mem_autopwr_mon`

## Requirements
- R1: The memory counts as selected when `sel_n_i` (active low) is 0 and `sel_i` (active high) is 1. Two select changes are wake events: a 0-to-1 change of `sel_i` while `sel_n_i` is 0, and a 1-to-0 change of `sel_n_i` while `sel_i` is 1.
- R2: A 1-to-0 change of `wr_n_i` (active low write strobe) while the memory is selected is a wake event.
- R3: A change of any bit of `addr_i` while the memory is selected is a wake event.
- R4: A change of any bit of `data_i` is a wake event only while the memory is selected and `wr_n_i` is 0. With `wr_n_i` at 1 it has no effect on `power_up_o` or `wake_o`.
- R5: `power_up_o` stays 1 for exactly `QUIET_CYC` clock cycles after the most recent wake event and then returns to 0, even while the memory stays selected. Every wake event restarts the full interval.
- R6: While the sampled selects show the memory deselected, `power_up_o` is 0. No change of the address, data or write strobe wakes the memory in that state.
- R7: A wake event in the cycle in which the interval would expire takes priority, and `power_up_o` stays 1 without a gap.
- R8: An input change made before clock edge k shows on the outputs after edge k+1. `wake_o` is a one-cycle pulse for each cycle that holds a wake event.
- R9: A synchronous active-low `rst_n` clears `power_up_o` and `wake_o` to 0. It also sets the stored pin history to deselected, with the write strobe inactive and address and data all zero. The first selection after reset is then seen as a select edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n_i | input | 1 | Active-low chip select |
| sel_i | input | 1 | Active-high chip select |
| wr_n_i | input | 1 | Active-low write strobe |
| addr_i | input | ADDR_W | Memory address pins |
| data_i | input | DATA_W | Memory data pins |
| power_up_o | output | 1 | 1 while the memory is in the powered state |
| wake_o | output | 1 | One-cycle pulse per qualified wake event |

## Verification
Two functions can meet in one cycle: the quiet counter reaching its last count and a fresh wake event reloading it. The bench sweeps the gap between address toggles across the interval length, so one toggle lands exactly on the expiry cycle. A behavioural model then demands that the power flag stays high with no gap. A second collision occurs when a select edge and a deselect arrive close together. The same cycle-by-cycle comparison judges both cases.

// File: rtl/mem_pwr_pkg.sv
package mem_pwr_pkg;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic wr_n;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{sel_n: 1'b1, sel: 1'b0, wr_n: 1'b1};

    function automatic logic ctl_selected(input ctl_t c);
        return (!c.sel_n) && c.sel;
    endfunction

endpackage

// File: rtl/mem_pwr_sampler.sv
module mem_pwr_sampler
    import mem_pwr_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output ctl_t              cur_ctl_o,
    output ctl_t              prv_ctl_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [ADDR_W-1:0] prv_addr_o,
    output logic [DATA_W-1:0] cur_data_o,
    output logic [DATA_W-1:0] prv_data_o
);

    typedef struct packed {
        ctl_t              cur_ctl;
        ctl_t              prv_ctl;
        logic [ADDR_W-1:0] cur_addr;
        logic [ADDR_W-1:0] prv_addr;
        logic [DATA_W-1:0] cur_data;
        logic [DATA_W-1:0] prv_data;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d = smp_q;
        if (!rst_n) begin
            smp_d.cur_ctl  = CTL_IDLE;
            smp_d.prv_ctl  = CTL_IDLE;
            smp_d.cur_addr = '0;
            smp_d.prv_addr = '0;
            smp_d.cur_data = '0;
            smp_d.prv_data = '0;
        end else begin
            smp_d.prv_ctl  = smp_q.cur_ctl;
            smp_d.prv_addr = smp_q.cur_addr;
            smp_d.prv_data = smp_q.cur_data;
            smp_d.cur_ctl  = ctl_i;
            smp_d.cur_addr = addr_i;
            smp_d.cur_data = data_i;
        end
    end

    always_ff @(posedge clk) begin
        smp_q <= smp_d;
    end

    assign cur_ctl_o  = smp_q.cur_ctl;
    assign prv_ctl_o  = smp_q.prv_ctl;
    assign cur_addr_o = smp_q.cur_addr;
    assign prv_addr_o = smp_q.prv_addr;
    assign cur_data_o = smp_q.cur_data;
    assign prv_data_o = smp_q.prv_data;

    // history shifts by exactly one sample per clock
    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (prv_addr_o == $past(cur_addr_o))); // R8

endmodule

// File: rtl/mem_pwr_wake_qual.sv
module mem_pwr_wake_qual
    import mem_pwr_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              cur_ctl_i,
    input  ctl_t              prv_ctl_i,
    input  logic [ADDR_W-1:0] cur_addr_i,
    input  logic [ADDR_W-1:0] prv_addr_i,
    input  logic [DATA_W-1:0] cur_data_i,
    input  logic [DATA_W-1:0] prv_data_i,
    output logic              sel_o,
    output logic              wake_evt_o
);

    logic [ADDR_W-1:0] addr_flip;
    logic [DATA_W-1:0] data_flip;

    for (genvar ai = 0; ai < ADDR_W; ai++) begin : g_addr_cmp
        assign addr_flip[ai] = cur_addr_i[ai] ^ prv_addr_i[ai];
    end

    for (genvar di = 0; di < DATA_W; di++) begin : g_data_cmp
        assign data_flip[di] = cur_data_i[di] ^ prv_data_i[di];
    end

    logic sel_now;
    logic sel_edge_evt;
    logic wr_edge_evt;
    logic addr_evt;
    logic data_evt;

    always_comb begin
        sel_now      = ctl_selected(cur_ctl_i);
        sel_edge_evt = (!prv_ctl_i.sel && cur_ctl_i.sel && !cur_ctl_i.sel_n)
                     || (prv_ctl_i.sel_n && !cur_ctl_i.sel_n && cur_ctl_i.sel);
        wr_edge_evt  = prv_ctl_i.wr_n && !cur_ctl_i.wr_n && sel_now;
        addr_evt     = (|addr_flip) && sel_now;
        data_evt     = (|data_flip) && sel_now && !cur_ctl_i.wr_n;
    end

    assign sel_o      = sel_now;
    assign wake_evt_o = sel_edge_evt || wr_edge_evt || addr_evt || data_evt;

    AST_NO_WAKE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt_o |-> (!cur_ctl_i.sel_n && cur_ctl_i.sel)); // R6

    AST_DATA_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_evt_o && cur_ctl_i.wr_n && (cur_addr_i == prv_addr_i)
         && (cur_ctl_i == prv_ctl_i)) |-> 1'b0); // R4

endmodule

// File: rtl/mem_pwr_timer.sv
module mem_pwr_timer #(
    parameter int QUIET_CYC = 16,
    localparam int CNT_W    = $clog2(QUIET_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic wake_evt_i,
    output logic power_up_o,
    output logic wake_o
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(QUIET_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pwr;
        logic             wake;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!rst_n) begin
            tmr_d.cnt  = '0;
            tmr_d.pwr  = 1'b0;
            tmr_d.wake = 1'b0;
        end else if (!sel_i) begin
            tmr_d.cnt  = '0;
            tmr_d.pwr  = 1'b0;
            tmr_d.wake = 1'b0;
        end else begin
            tmr_d.wake = wake_evt_i;
            if (wake_evt_i) begin
                tmr_d.cnt = CNT_FULL;
            end else if (tmr_q.cnt != '0) begin
                tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
            end
            tmr_d.pwr = (tmr_d.cnt != '0);
        end
    end

    always_ff @(posedge clk) begin
        tmr_q <= tmr_d;
    end

    assign power_up_o = tmr_q.pwr;
    assign wake_o     = tmr_q.wake;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= CNT_FULL); // R5

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.cnt != '0 && sel_i && !wake_evt_i) |=> (tmr_q.cnt == $past(tmr_q.cnt) - CNT_W'(1))); // R5

    AST_EXPIRY_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.cnt == CNT_W'(1) && sel_i && wake_evt_i) |=> power_up_o); // R7

endmodule

// File: rtl/mem_autopwr_mon.sv
module mem_autopwr_mon
    import mem_pwr_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int QUIET_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_i,
    input  logic              sel_i,
    input  logic              wr_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              power_up_o,
    output logic              wake_o
);

    ctl_t              pin_ctl;
    ctl_t              cur_ctl;
    ctl_t              prv_ctl;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] prv_addr;
    logic [DATA_W-1:0] cur_data;
    logic [DATA_W-1:0] prv_data;
    logic              sel_cur;
    logic              wake_evt;

    assign pin_ctl = '{sel_n: sel_n_i, sel: sel_i, wr_n: wr_n_i};

    mem_pwr_sampler #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_i      (pin_ctl),
        .addr_i     (addr_i),
        .data_i     (data_i),
        .cur_ctl_o  (cur_ctl),
        .prv_ctl_o  (prv_ctl),
        .cur_addr_o (cur_addr),
        .prv_addr_o (prv_addr),
        .cur_data_o (cur_data),
        .prv_data_o (prv_data)
    );

    mem_pwr_wake_qual #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_ctl_i  (cur_ctl),
        .prv_ctl_i  (prv_ctl),
        .cur_addr_i (cur_addr),
        .prv_addr_i (prv_addr),
        .cur_data_i (cur_data),
        .prv_data_i (prv_data),
        .sel_o      (sel_cur),
        .wake_evt_o (wake_evt)
    );

    mem_pwr_timer #(
        .QUIET_CYC (QUIET_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel_cur),
        .wake_evt_i (wake_evt),
        .power_up_o (power_up_o),
        .wake_o     (wake_o)
    );

    AST_DESEL_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_cur |=> !power_up_o); // R6

    AST_WAKE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> (wake_o && power_up_o)); // R8

    AST_PULSE_ONLY_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_evt |=> !wake_o); // R8

endmodule

// File: tb/mem_autopwr_mon_tb.sv
`timescale 1ns/1ps
module mem_autopwr_mon_tb;

    localparam int AW = 17;
    localparam int DW = 8;
    localparam int QC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          sel = 1'b0;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic          power_up;
    logic          wake;

    always #2 clk = ~clk;

    mem_autopwr_mon #(.ADDR_W(AW), .DATA_W(DW), .QUIET_CYC(QC)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sel_i(sel), .wr_n_i(wr_n),
        .addr_i(addr), .data_i(data), .power_up_o(power_up), .wake_o(wake)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R9";

    // behavioural reference: sample history and quiet countdown
    bit        h_seln [$];
    bit        h_sel  [$];
    bit        h_wrn  [$];
    int        h_addr [$];
    int        h_data [$];
    int        m_left = 0;
    bit        m_pow = 0;
    bit        m_wake = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            h_seln = {1'b1, 1'b1}; h_sel = {1'b0, 1'b0}; h_wrn = {1'b1, 1'b1};
            h_addr = {0, 0}; h_data = {0, 0};
            m_left = 0; m_pow = 0; m_wake = 0;
        end else begin
            bit on, ev;
            on = !h_seln[1] && h_sel[1];
            ev = 0;
            if (h_sel[1] && !h_sel[0] && !h_seln[1]) ev = 1;
            if (!h_seln[1] && h_seln[0] && h_sel[1]) ev = 1;
            if (on && h_wrn[0] && !h_wrn[1]) ev = 1;
            if (on && h_addr[1] != h_addr[0]) ev = 1;
            if (on && !h_wrn[1] && h_data[1] != h_data[0]) ev = 1;
            if (!on) begin m_left = 0; ev = 0; end
            else if (ev) m_left = QC;
            else if (m_left > 0) m_left--;
            m_pow = (m_left > 0);
            m_wake = ev;
            void'(h_seln.pop_front()); h_seln.push_back(sel_n);
            void'(h_sel.pop_front());  h_sel.push_back(sel);
            void'(h_wrn.pop_front());  h_wrn.push_back(wr_n);
            void'(h_addr.pop_front()); h_addr.push_back(int'(addr));
            void'(h_data.pop_front()); h_data.push_back(int'(data));
        end
    end

    task automatic compare();
        n_cmp++;
        if (power_up !== m_pow) begin
            n_bad++;
            $display("FAIL %s power_up actual=%0b expected=%0b t=%0t", phase, power_up, m_pow, $time);
        end
        n_cmp++;
        if (wake !== m_wake) begin
            n_bad++;
            $display("FAIL %s wake actual=%0b expected=%0b t=%0t", phase, wake, m_wake, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic expect_lvl(input bit ep, input bit ew);
        n_cmp++;
        if (power_up !== ep || wake !== ew) begin
            n_bad++;
            $display("FAIL %s directed actual=%0b%0b expected=%0b%0b", phase, power_up, wake, ep, ew);
        end
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        phase = "R9";
        tick(3);
        expect_lvl(0, 0);
        rst_n = 1'b1;
        tick(2);
        expect_lvl(0, 0);

        // R1: select-low falling with select-high already 1
        phase = "R1";
        sel = 1'b1; tick(1);
        sel_n = 1'b0; tick(1);
        tick(1); expect_lvl(1, 1);
        tick(QC + 3);
        expect_lvl(0, 0);   // R5 timeout while selected
        // R1: select-high rising with select-low held 0
        sel = 1'b0; tick(3);
        sel = 1'b1; tick(2); expect_lvl(1, 1);
        tick(4);

        // R6: deselect while powered drops to standby, no wakes
        phase = "R6";
        sel_n = 1'b1; tick(2); expect_lvl(0, 0);
        for (int i = 0; i < 6; i++) begin
            addr = AW'(i * 37 + 1); data = DW'(i + 5); wr_n = i[0]; tick(1);
        end
        wr_n = 1'b1; tick(2); expect_lvl(0, 0);
        sel_n = 1'b0; tick(QC + 4);

        // R3: address changes while selected
        phase = "R3";
        addr = addr ^ AW'(1 << (AW - 1)); tick(2); expect_lvl(1, 1);
        tick(3);
        addr = addr ^ AW'(1); tick(QC + 3);

        // R2: write strobe falling edge
        phase = "R2";
        wr_n = 1'b0; tick(2); expect_lvl(1, 1);
        tick(QC + 2);
        expect_lvl(0, 0);

        // R4: data change with write active wakes
        phase = "R4";
        data = 8'hA5; tick(2); expect_lvl(1, 1);
        wr_n = 1'b1; tick(QC + 3);
        for (int i = 0; i < 5; i++) begin
            data = data + 8'h11; tick(1);
        end
        tick(1); expect_lvl(0, 0);

        // R5: repeated reloads keep power up
        phase = "R5";
        for (int i = 0; i < 8; i++) begin
            addr = addr + AW'(3); tick(QC - 2);
        end
        tick(QC + 2);

        // R7: toggle gaps around the interval length, hitting expiry exactly
        phase = "R7";
        for (int g = QC - 3; g <= QC + 2; g++) begin
            addr = addr + AW'(1); tick(g);
        end
        tick(QC + 2);

        // R8 with R1: mixed pseudo-random activity
        phase = "R8";
        begin
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 600; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                if (lf[3:0] == 4'h0) sel_n = ~sel_n;
                if (lf[7:4] == 4'h1) sel = ~sel;
                if (lf[2:0] == 3'h5) wr_n = ~wr_n;
                if (lf[9:6] == 4'h2) addr = addr ^ AW'(lf);
                if (lf[12:9] == 4'h3) data = data ^ DW'(lf);
                tick(1);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule